// File: doc/BRIEF.md
# USB Device Interrupt Status Register

This block is the sticky interrupt status word of a USB device controller with five endpoints. It watches single-cycle event strobes from the endpoint engines, and per endpoint and direction it latches transfer-complete events and, when enabled, NAK events. It also latches a once-per-millisecond frame tick and a summary of the device-status-change flags. Each event sets one bit, and the bit stays set until software clears it by writing a one to that position.

The 1 ms tick comes from an internal prescaler of `TICK_CYCLES` clocks. The tick counts only while the bus-power-debounced and connected levels are both high. The prescaler starts again from zero whenever either level drops. A registered interrupt line is raised whenever any status bit is set.

The block has no data stream. Every pin is a plain control or status signal, so there is no valid/ready handshake and no back-pressure. The write port is a one-cycle strobe with data and takes effect at the next clock edge. The read value always shows the current register contents.

Top module: `usbd_irq_stat`

## Requirements
- R1: After reset, `rd_data` is 0 and `irq` is 0.
- R2: Bit layout of `rd_data`: the OUT direction of endpoint k is bit 2k and the IN direction is bit 2k+1, for k = 0..4. The frame bit is bit 30 and the device-status bit is bit 31. Every other bit reads 0, even after a write of ones.
- R3: A write with `wr_en` high clears every status bit where `wr_data` holds a one, at the next edge. Bits where `wr_data` holds a zero are unchanged.
- R4: If a set event and a clearing write hit the same bit in the same cycle, the bit is 1 afterwards.
- R5: The control OUT bit (bit 0) sets on `ep_done_out[0]` or on `setup_rx`.
- R6: The control IN bit (bit 1) sets on `ep_done_in[0]`. `setup_rx` does not set it.
- R7: For endpoints 1 to 4, `ep_done_out[k]` sets bit 2k and `ep_done_in[k]` sets bit 2k+1. These strobes mark hardware releasing the buffer.
- R8: A NAK strobe sets its direction bit only when its class enable is high. `nak_en_ctl_out` gates endpoint 0 OUT and `nak_en_ctl_in` gates endpoint 0 IN. `nak_en_gen_out` and `nak_en_gen_in` gate endpoints 1 to 4 for OUT and IN.
- R9: While `vbus_ok` and `dev_conn` are both high, bit 30 sets after every `TICK_CYCLES` consecutive edges with both high. A low on either level restarts the count.
- R10: Bit 31 sets at the next edge whenever any bit of `dev_chg` is high.
- R11: `irq` is high in the cycle after any status bit is 1. It drops in the cycle after the last set bit has been cleared.
- R12: A set bit stays set until it is cleared by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ep_done_out | input | NUM_EP | OUT transfer-complete strobe per endpoint |
| ep_done_in | input | NUM_EP | IN transfer-complete strobe per endpoint |
| setup_rx | input | 1 | SETUP received on the control endpoint |
| nak_out | input | NUM_EP | NAK sent on OUT, per endpoint |
| nak_in | input | NUM_EP | NAK sent on IN, per endpoint |
| nak_en_ctl_out | input | 1 | NAK interrupt enable, control OUT |
| nak_en_ctl_in | input | 1 | NAK interrupt enable, control IN |
| nak_en_gen_out | input | 1 | NAK interrupt enable, endpoints 1 to 4 OUT |
| nak_en_gen_in | input | 1 | NAK interrupt enable, endpoints 1 to 4 IN |
| vbus_ok | input | 1 | Debounced bus-power level |
| dev_conn | input | 1 | Device-connected level |
| dev_chg | input | DEVCHG_W | Device-status-change flags |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data, ones clear bits |
| rd_data | output | 32 | Current status word |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that reset is held low for at least one edge. They also assume that every strobe input is a clean level sampled at the clock edge. They place no limit on how many strobes, writes or change flags may arrive together, so the random stimulus fires strobes, enables, gating levels and clearing writes independently on every cycle, including set and clear on the same bit. The prescaler checks assume `TICK_CYCLES` is at least 2. The bench uses 16 so that ticks and restarts occur often.

// File: rtl/usbd_irq_pkg.sv
package usbd_irq_pkg;
  localparam int REG_W      = 32;
  localparam int FRAME_POS  = 30;
  localparam int DEVCHG_POS = 31;

  function automatic int out_pos(input int ep);
    return 2 * ep;
  endfunction

  function automatic int in_pos(input int ep);
    return 2 * ep + 1;
  endfunction
endpackage

// File: rtl/usbd_ep_evt_map.sv
module usbd_ep_evt_map #(
  parameter int NUM_EP = 5
) (
  input  logic [NUM_EP-1:0]   done_out,
  input  logic [NUM_EP-1:0]   done_in,
  input  logic                setup_rx,
  input  logic [NUM_EP-1:0]   nak_out,
  input  logic [NUM_EP-1:0]   nak_in,
  input  logic                en_ctl_out,
  input  logic                en_ctl_in,
  input  logic                en_gen_out,
  input  logic                en_gen_in,
  output logic [2*NUM_EP-1:0] ep_set
);
  import usbd_irq_pkg::*;

  for (genvar k = 0; k < NUM_EP; k++) begin : g_ep
    if (k == 0) begin : g_ctl
      // control endpoint: SETUP only reaches the OUT side
      assign ep_set[out_pos(k)] = done_out[k] | setup_rx | (nak_out[k] & en_ctl_out);
      assign ep_set[in_pos(k)]  = done_in[k] | (nak_in[k] & en_ctl_in);
    end else begin : g_gen
      assign ep_set[out_pos(k)] = done_out[k] | (nak_out[k] & en_gen_out);
      assign ep_set[in_pos(k)]  = done_in[k] | (nak_in[k] & en_gen_in);
    end
  end
endmodule

// File: rtl/usbd_frame_prescale.sv
module usbd_frame_prescale #(
  parameter int TICK_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vbus_ok,
  input  logic dev_conn,
  output logic tick
);
  localparam int CNT_W = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

  logic             gate;
  logic [CNT_W-1:0] cnt;

  assign gate = vbus_ok & dev_conn;
  assign tick = gate && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !gate || tick) cnt <= '0;
    else                         cnt <= cnt + 1'b1;
  end

  // R9
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/usbd_w1c_bank.sv
module usbd_w1c_bank #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)        q[b] <= 1'b0;
      else if (set_i[b]) q[b] <= 1'b1;
      else if (clr_i[b]) q[b] <= 1'b0;
    end

    // R3
    clear_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[b] && !set_i[b]) |=> !q[b]);
    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[b] |=> q[b]);
    // R12
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q[b] && !clr_i[b]) |=> q[b]);
  end
endmodule

// File: rtl/usbd_irq_stat.sv
module usbd_irq_stat #(
  parameter int NUM_EP      = 5,
  parameter int DEVCHG_W    = 7,
  parameter int TICK_CYCLES = 250000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_EP-1:0]   ep_done_out,
  input  logic [NUM_EP-1:0]   ep_done_in,
  input  logic                setup_rx,
  input  logic [NUM_EP-1:0]   nak_out,
  input  logic [NUM_EP-1:0]   nak_in,
  input  logic                nak_en_ctl_out,
  input  logic                nak_en_ctl_in,
  input  logic                nak_en_gen_out,
  input  logic                nak_en_gen_in,
  input  logic                vbus_ok,
  input  logic                dev_conn,
  input  logic [DEVCHG_W-1:0] dev_chg,
  input  logic                wr_en,
  input  logic [31:0]         wr_data,
  output logic [31:0]         rd_data,
  output logic                irq
);
  import usbd_irq_pkg::*;

  localparam int EP_BITS  = 2 * NUM_EP;
  localparam int NB       = EP_BITS + 2;
  localparam int FRM_IDX  = EP_BITS;
  localparam int DEV_IDX  = EP_BITS + 1;

  logic [EP_BITS-1:0] ep_set;
  logic               frame_tick;
  logic [NB-1:0]      set_v, clr_v, st_q;
  logic               irq_q;
  logic               unused_wr;

  usbd_ep_evt_map #(.NUM_EP(NUM_EP)) u_map (
    .done_out  (ep_done_out),
    .done_in   (ep_done_in),
    .setup_rx  (setup_rx),
    .nak_out   (nak_out),
    .nak_in    (nak_in),
    .en_ctl_out(nak_en_ctl_out),
    .en_ctl_in (nak_en_ctl_in),
    .en_gen_out(nak_en_gen_out),
    .en_gen_in (nak_en_gen_in),
    .ep_set    (ep_set)
  );

  usbd_frame_prescale #(.TICK_CYCLES(TICK_CYCLES)) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .vbus_ok (vbus_ok),
    .dev_conn(dev_conn),
    .tick    (frame_tick)
  );

  assign set_v = {(|dev_chg), frame_tick, ep_set};
  assign clr_v = wr_en ? {wr_data[DEVCHG_POS], wr_data[FRAME_POS], wr_data[EP_BITS-1:0]}
                       : '0;
  assign unused_wr = ^wr_data[FRAME_POS-1:EP_BITS];

  usbd_w1c_bank #(.WIDTH(NB)) u_bank (
    .clk  (clk),
    .rst_n(rst_n),
    .set_i(set_v),
    .clr_i(clr_v),
    .q    (st_q)
  );

  always_comb begin
    rd_data                   = '0;
    rd_data[EP_BITS-1:0]      = st_q[EP_BITS-1:0];
    rd_data[FRAME_POS]        = st_q[FRM_IDX];
    rd_data[DEVCHG_POS]       = st_q[DEV_IDX];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |st_q;
  end
  assign irq = irq_q;

  // R11
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rd_data) |=> irq);
  // R11
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data == '0) |=> !irq);
  // R6
  setup_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_rx && !ep_done_in[0] && !nak_in[0] && !rd_data[1]) |=> !rd_data[1]);
  // R10
  dev_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_chg) |=> rd_data[DEVCHG_POS]);
endmodule

// File: tb/usbd_irq_stat_bench.sv
`timescale 1ns/1ps
module usbd_irq_stat_bench;
  localparam int NUM_EP = 5;
  localparam int DW     = 7;
  localparam int TICKS  = 16;
  localparam logic [31:0] IMPL = 32'hC000_03FF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM_EP-1:0] done_out = '0, done_in = '0, nak_o = '0, nak_i = '0;
  logic setup = 1'b0, en_co = 1'b0, en_ci = 1'b0, en_go = 1'b0, en_gi = 1'b0;
  logic vbus = 1'b0, conn = 1'b0, wr_en = 1'b0;
  logic [DW-1:0] chg = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic irq;

  int checks = 0, fails = 0, bcnt = 0;
  logic [31:0] exp_st = '0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  usbd_irq_stat #(.NUM_EP(NUM_EP), .DEVCHG_W(DW), .TICK_CYCLES(TICKS)) u_usbd_irq_stat (
    .clk(clk), .rst_n(rst_n), .ep_done_out(done_out), .ep_done_in(done_in),
    .setup_rx(setup), .nak_out(nak_o), .nak_in(nak_i),
    .nak_en_ctl_out(en_co), .nak_en_ctl_in(en_ci), .nak_en_gen_out(en_go),
    .nak_en_gen_in(en_gi), .vbus_ok(vbus), .dev_conn(conn), .dev_chg(chg),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_next(input logic [31:0] cur, input logic tick);
    logic [31:0] s = '0;
    for (int k = 0; k < NUM_EP; k++) begin
      s[2*k]   = done_out[k] | (nak_o[k] & ((k == 0) ? en_co : en_go)) | ((k == 0) & setup);
      s[2*k+1] = done_in[k]  | (nak_i[k] & ((k == 0) ? en_ci : en_gi));
    end
    s[30] = tick;
    s[31] = |chg;
    return ((cur & ~(wr_en ? wr_data : 32'h0)) | s) & IMPL;
  endfunction

  task automatic idle();
    done_out = '0; done_in = '0; nak_o = '0; nak_i = '0;
    setup = 1'b0; chg = '0; wr_en = 1'b0; wr_data = '0;
  endtask

  // one clock edge with the model advanced alongside
  task automatic cycle();
    logic [31:0] old = exp_st;
    logic tick = 1'b0;
    if (!(vbus && conn)) bcnt = 0;
    else if (bcnt == TICKS - 1) begin tick = 1'b1; bcnt = 0; end
    else bcnt++;
    exp_st = model_next(exp_st, tick);
    @(posedge clk);
    @(negedge clk);
    chk("R12 model", rd_data, exp_st);
    chk("R11 irq", {31'h0, irq}, {31'h0, |old});
    idle();
  endtask

  task automatic clear_all();
    wr_en = 1'b1; wr_data = 32'hFFFF_FFFF; cycle();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(4ns * 200000);
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset rd_data", rd_data, 32'h0);
    chk("R1 reset irq", {31'h0, irq}, 32'h0);

    // R5 / R6 control endpoint
    done_out[0] = 1'b1; cycle();
    chk("R5 done sets bit0", rd_data & 32'h3, 32'h1);
    clear_all();
    setup = 1'b1; cycle();
    chk("R5 R6 setup sets bit0 only", rd_data & 32'h3, 32'h1);
    clear_all();
    done_in[0] = 1'b1; cycle();
    chk("R6 done_in sets bit1", rd_data, 32'h2);
    clear_all();

    // R7 generic endpoints
    for (int k = 1; k < NUM_EP; k++) begin
      done_out[k] = 1'b1; cycle();
      chk("R7 out bit", rd_data, 32'h1 << (2*k));
      clear_all();
      done_in[k] = 1'b1; cycle();
      chk("R7 in bit", rd_data, 32'h1 << (2*k+1));
      clear_all();
    end

    // R8 NAK enables
    nak_o[0] = 1'b1; cycle();
    chk("R8 ctl out nak disabled", rd_data, 32'h0);
    en_co = 1'b1; nak_o[0] = 1'b1; cycle();
    chk("R8 ctl out nak enabled", rd_data, 32'h1);
    clear_all();
    en_ci = 1'b1; nak_i[3] = 1'b1; cycle();
    chk("R8 ctl in enable does not gate ep3", rd_data, 32'h0);
    en_gi = 1'b1; nak_i[2] = 1'b1; cycle();
    chk("R8 gen in nak enabled", rd_data, 32'h20);
    en_go = 1'b0; nak_o[4] = 1'b1; cycle();
    chk("R8 gen out nak disabled", rd_data, 32'h20);
    clear_all();
    en_co = 0; en_ci = 0; en_gi = 0;

    // R3 write-one-to-clear
    done_out = '1; done_in = '1; cycle();
    wr_en = 1'b1; wr_data = 32'h0; cycle();
    chk("R3 zero write keeps bits", rd_data, 32'h3FF);
    wr_en = 1'b1; wr_data = 32'h0000_0155; cycle();
    chk("R3 selective clear", rd_data, 32'h2AA);

    // R4 set wins over clear
    done_out[1] = 1'b1; wr_en = 1'b1; wr_data = 32'h0000_0004; cycle();
    chk("R4 set beats clear", rd_data & 32'h4, 32'h4);

    // R10 and R2 full layout
    chg = 7'b0100000; done_out = '1; done_in = '1; cycle();
    chk("R10 dev bit", rd_data & 32'h8000_0000, 32'h8000_0000);
    chk("R2 layout", rd_data, 32'h8000_03FF);
    wr_en = 1'b1; wr_data = 32'h3FFF_FC00; cycle();
    chk("R2 spare bits stay zero", rd_data, 32'h8000_03FF);

    // R11 irq falls one cycle after last clear
    clear_all();
    chk("R11 status empty", rd_data, 32'h0);
    cycle();
    chk("R11 irq low", {31'h0, irq}, 32'h0);

    // R9 frame tick and restart
    vbus = 1'b1; conn = 1'b1;
    repeat (TICKS - 1) cycle();
    chk("R9 no tick yet", rd_data & 32'h4000_0000, 32'h0);
    cycle();
    chk("R9 tick", rd_data & 32'h4000_0000, 32'h4000_0000);
    conn = 1'b0; wr_en = 1'b1; wr_data = 32'hFFFF_FFFF; cycle();
    conn = 1'b1;
    repeat (10) cycle();
    vbus = 1'b0; cycle();
    vbus = 1'b1;
    repeat (TICKS - 1) cycle();
    chk("R9 restart no early tick", rd_data & 32'h4000_0000, 32'h0);
    cycle();
    chk("R9 tick after restart", rd_data & 32'h4000_0000, 32'h4000_0000);

    // R12 random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      for (int k = 0; k < NUM_EP; k++) begin
        done_out[k] = ($urandom_range(0, 9) == 0);
        done_in[k]  = ($urandom_range(0, 9) == 0);
        nak_o[k]    = ($urandom_range(0, 7) == 0);
        nak_i[k]    = ($urandom_range(0, 7) == 0);
      end
      setup = ($urandom_range(0, 15) == 0);
      chg   = ($urandom_range(0, 15) == 0) ? DW'($urandom) : '0;
      en_co = $urandom_range(0, 1); en_ci = $urandom_range(0, 1);
      en_go = $urandom_range(0, 1); en_gi = $urandom_range(0, 1);
      if ($urandom_range(0, 31) == 0) vbus = ~vbus;
      if ($urandom_range(0, 31) == 0) conn = ~conn;
      wr_en   = ($urandom_range(0, 3) == 0);
      wr_data = $urandom;
      cycle();
    end

    done_flag = 1;
    finish_run();
  end
endmodule